// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time Counter

This block keeps a free-running 40-bit nanosecond count for precision time protocol use. On every cycle of its 8 ns reference clock the count moves forward by a fixed 8 ns. A 32-bit sub-nanosecond fraction also receives a signed, software-set trim on every cycle. A carry out of that fraction adds one nanosecond to the step, and a borrow takes one away. The rate of the clock can thus be trimmed in both directions, in steps of 2^-32 ns per cycle.

Software reaches the counter through a 32-bit register port with three locations: the low time word, the high time word and the rate trim. The split time word reads and writes as one value. Reading the low word freezes the upper bits in a shadow for the high-word read that follows. Writing the low word only stages it, and the write to the high word loads both halves at once. A one-cycle wrap pulse marks each rollover of the 40-bit count, so that software can extend the count beyond 40 bits.

Top module: `fnc_ns_clock`

## Requirements
- R1: With a zero rate trim, the nanosecond count increases by exactly 8 on every clock cycle.
- R2: When rate bit 31 is 0, rate bits 30:0 are added to the 32-bit fraction on each cycle. A carry out of the fraction makes that cycle's step 9 ns.
- R3: When rate bit 31 is 1, rate bits 30:0 are subtracted from the fraction on each cycle. A borrow makes that cycle's step 7 ns.
- R4: The address map is 0 for the low time word (count bits 31:0), 1 for the high time word (count bits 39:32 in data bits 7:0, with data bits 31:8 reading zero) and 2 for the rate trim. The count wraps modulo 2^40.
- R5: A read of address 0 returns the live count bits 31:0 and captures bits 39:32 into a shadow. A later read of address 1 returns that shadow, even when the live count has since crossed a 2^32 boundary.
- R6: A write to address 0 is only staged and leaves the running count unchanged. A write to address 1 loads the count with {wdata[7:0], staged low word} and clears the fraction.
- R7: A load takes precedence over the per-cycle step in the same cycle. A low-word read issued in the cycle after the load returns exactly the loaded low word.
- R8: `wrap_pulse` is high for exactly one cycle: the first cycle in which the count shows its post-rollover value.
- R9: Reset (synchronous, active high) clears the count, the fraction, the rate trim and the staged word. Read data appears on `bus_rdata` one cycle after `bus_rd`, qualified by `bus_rvalid`.
- R10: A read of address 2 returns the last value written to the rate trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock (8 ns) |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register select (0 low time, 1 high time, 2 rate) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| wrap_pulse | output | 1 | One-cycle pulse on 40-bit rollover |

## Verification
The hardest situation to reach from the ports is a coherent split read that straddles a 2^32 ns boundary: the low word must be read just before bit 32 changes, and the high word just after. Reaching that boundary by counting would take seconds of simulated time, so the stimulus loads a time a single step below the boundary and then reads low and high on back-to-back cycles. The 2^40 rollover and its pulse are reached the same way. A fractional borrow or carry is placed on a known cycle by loading the time, which clears the fraction, and then applying a quarter-nanosecond trim. Random rate writes, loads and read pairs are then compared against a reference model kept in the bench.

// File: rtl/fnc_pkg.sv
package fnc_pkg;

    localparam int NS_W    = 40;
    localparam int FRAC_W  = 32;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int HI_W    = NS_W - BUS_W;
    localparam int MAG_W   = FRAC_W - 1;
    localparam int STEP_NS = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TIME_LO = 2'd0,
        SEL_TIME_HI = 2'd1,
        SEL_RATE    = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } rate_t;

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        adj_e              adj;
    } frac_res_t;

    function automatic frac_res_t frac_next(logic [FRAC_W-1:0] f, rate_t r);
        logic [FRAC_W:0] s;
        frac_res_t       o;
        if (r.neg) begin
            s     = {1'b0, f} - {2'b00, r.mag};
            o.adj = s[FRAC_W] ? ADJ_DOWN : ADJ_NONE;
        end else begin
            s     = {1'b0, f} + {2'b00, r.mag};
            o.adj = s[FRAC_W] ? ADJ_UP : ADJ_NONE;
        end
        o.frac = s[FRAC_W-1:0];
        return o;
    endfunction

    function automatic logic [NS_W-1:0] step_of(adj_e a);
        logic [NS_W-1:0] st;
        st = NS_W'(STEP_NS);
        case (a)
            ADJ_UP:   st = NS_W'(STEP_NS + 1);
            ADJ_DOWN: st = NS_W'(STEP_NS - 1);
            default:  st = NS_W'(STEP_NS);
        endcase
        return st;
    endfunction

endpackage

// File: rtl/fnc_frac_acc.sv
module fnc_frac_acc
    import fnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  rate_t             rate_i,
    output adj_e              adj_o,
    output logic [FRAC_W-1:0] frac_o
);

    logic [FRAC_W-1:0] frac_q;
    frac_res_t         res;

    always_comb begin
        res   = frac_next(frac_q, rate_i);
        adj_o = clr_i ? ADJ_NONE : res.adj;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
        end else if (clr_i) begin
            frac_q <= '0;
        end else begin
            frac_q <= res.frac;
        end
    end

    assign frac_o = frac_q;

    // R3
    sign_dir_chk: assert property (@(posedge clk) disable iff (rst)
        rate_i.neg |-> (adj_o != ADJ_UP));

    // R2
    pos_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !rate_i.neg && adj_o == ADJ_NONE) |=> (frac_q >= $past(frac_q)));

    // R6
    frac_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (frac_q == '0));

endmodule

// File: rtl/fnc_ns_count.sv
module fnc_ns_count
    import fnc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [NS_W-1:0] load_val_i,
    input  adj_e            adj_i,
    output logic [NS_W-1:0] ns_o,
    output logic            wrap_o
);

    logic [NS_W-1:0] ns_q;
    logic            wrap_q;
    logic [NS_W:0]   sum;

    always_comb begin
        sum = {1'b0, ns_q} + {1'b0, step_of(adj_i)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q   <= '0;
            wrap_q <= 1'b0;
        end else if (load_i) begin
            ns_q   <= load_val_i;
            wrap_q <= 1'b0;
        end else begin
            ns_q   <= sum[NS_W-1:0];
            wrap_q <= sum[NS_W];
        end
    end

    assign ns_o   = ns_q;
    assign wrap_o = wrap_q;

    // R1
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (((ns_q - $past(ns_q)) >= NS_W'(STEP_NS - 1)) &&
                     ((ns_q - $past(ns_q)) <= NS_W'(STEP_NS + 1))));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (ns_q == $past(load_val_i)));

    // R8
    wrap_small_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (ns_q < NS_W'(2 * STEP_NS)));

    // R8
    wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q);

endmodule

// File: rtl/fnc_bus_regs.sv
module fnc_bus_regs
    import fnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [NS_W-1:0]   ns_i,
    output rate_t             rate_o,
    output logic              load_o,
    output logic [NS_W-1:0]   load_val_o,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              rvalid_o
);

    reg_sel_e          sel;
    logic [BUS_W-1:0]  staged_lo_q;
    logic [HI_W-1:0]   shadow_hi_q;
    rate_t             rate_q;
    logic [BUS_W-1:0]  rdata_q;
    logic              rvalid_q;
    logic [BUS_W-1:0]  rd_mux;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        case (sel)
            SEL_TIME_LO: rd_mux = ns_i[BUS_W-1:0];
            SEL_TIME_HI: rd_mux = {{(BUS_W-HI_W){1'b0}}, shadow_hi_q};
            SEL_RATE:    rd_mux = rate_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_lo_q <= '0;
            shadow_hi_q <= '0;
            rate_q      <= '0;
            rdata_q     <= '0;
            rvalid_q    <= 1'b0;
        end else begin
            rvalid_q <= rd_i;
            if (rd_i) begin
                rdata_q <= rd_mux;
                if (sel == SEL_TIME_LO) begin
                    shadow_hi_q <= ns_i[NS_W-1:BUS_W];
                end
            end
            if (wr_i) begin
                case (sel)
                    SEL_TIME_LO: staged_lo_q <= wdata_i;
                    SEL_RATE:    rate_q      <= rate_t'(wdata_i);
                    default:     ;
                endcase
            end
        end
    end

    assign load_o     = wr_i && (sel == SEL_TIME_HI);
    assign load_val_o = {wdata_i[HI_W-1:0], staged_lo_q};
    assign rate_o     = rate_q;
    assign rdata_o    = rdata_q;
    assign rvalid_o   = rvalid_q;

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_i && sel == SEL_TIME_LO) |=> $stable(shadow_hi_q));

    // R10
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && sel == SEL_RATE) |=> $stable(rate_q));

    // R9
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> rvalid_q);

    // R4
    hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && sel == SEL_TIME_HI) |=> (rdata_q[BUS_W-1:HI_W] == '0));

endmodule

// File: rtl/fnc_ns_clock.sv
module fnc_ns_clock
    import fnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic              wrap_pulse
);

    rate_t             rate;
    logic              load;
    logic [NS_W-1:0]   load_val;
    logic [NS_W-1:0]   ns;
    adj_e              adj;
    logic [FRAC_W-1:0] frac;

    fnc_bus_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .ns_i       (ns),
        .rate_o     (rate),
        .load_o     (load),
        .load_val_o (load_val),
        .rdata_o    (bus_rdata),
        .rvalid_o   (bus_rvalid)
    );

    fnc_frac_acc u_frac (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load),
        .rate_i (rate),
        .adj_o  (adj),
        .frac_o (frac)
    );

    fnc_ns_count u_count (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .adj_i      (adj),
        .ns_o       (ns),
        .wrap_o     (wrap_pulse)
    );

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ns == '0 && frac == '0 && rate == '0 && !wrap_pulse));

endmodule

// File: tb/sim_fnc_ns_clock.sv
module sim_fnc_ns_clock;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        wrap_pulse;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fnc_ns_clock u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .wrap_pulse(wrap_pulse)
    );

    // Reference model built from the requirements
    logic [39:0] m_ns;
    logic [31:0] m_frac, m_rate, m_stage, m_exp;
    logic [7:0]  m_shadow;
    logic        m_wrap;

    function automatic logic [40:0] m_step(logic [39:0] n, logic [31:0] f, logic [31:0] r,
                                           output logic [31:0] fo);
        logic signed [34:0] t;
        int st;
        st = 8;
        if (r[31]) begin
            t = $signed({3'b000, f}) - $signed({4'b0000, r[30:0]});
            if (t < 0) begin st = 7; t = t + 35'sh1_0000_0000; end
        end else begin
            t = $signed({3'b000, f}) + $signed({4'b0000, r[30:0]});
            if (t >= 35'sh1_0000_0000) begin st = 9; t = t - 35'sh1_0000_0000; end
        end
        fo = t[31:0];
        return {1'b0, n} + 41'(st);
    endfunction

    always @(posedge clk) begin
        logic [40:0] s;
        logic [31:0] fo;
        if (rst) begin
            m_ns = '0; m_frac = '0; m_rate = '0; m_stage = '0; m_shadow = '0; m_wrap = 1'b0;
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: begin m_exp = m_ns[31:0]; m_shadow = m_ns[39:32]; end
                    2'd1: m_exp = {24'd0, m_shadow};
                    2'd2: m_exp = m_rate;
                    default: m_exp = '0;
                endcase
            end
            if (bus_wr && bus_addr == 2'd1) begin
                m_ns = {bus_wdata[7:0], m_stage}; m_frac = '0; m_wrap = 1'b0;
            end else begin
                s = m_step(m_ns, m_frac, m_rate, fo);
                m_ns = s[39:0]; m_frac = fo; m_wrap = s[40];
            end
            if (bus_wr && bus_addr == 2'd0) m_stage = bus_wdata;
            if (bus_wr && bus_addr == 2'd2) m_rate = bus_wdata;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge
    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        chk("R9 rvalid", {31'd0, bus_rvalid}, 32'd1);
    endtask

    task automatic load(logic [39:0] t);
        wr(2'd0, t[31:0]);
        wr(2'd1, {24'd0, t[39:32]});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        chk("R9 wrap after reset", {31'd0, wrap_pulse}, 32'd0);
        rd(2'd0, v); chk("R9 count after reset", v, 32'd0);
        rd(2'd2, v); chk("R9 rate after reset", v, 32'd0);
        // R1 nominal rate: low read at edge 3 after release -> 16
        rd(2'd0, v); chk("R1 base step", v, 32'd16);

        // R7 load beats step; R5 split read across 2^32 boundary
        load(40'h01_FFFF_FFF8);
        rd(2'd0, v); chk("R7 load value", v, 32'hFFFF_FFF8);
        rd(2'd1, v); chk("R5 shadow high", v, 32'h0000_0001);
        rd(2'd0, v); chk("R5 live low", v, 32'h0000_0008);
        rd(2'd1, v); chk("R5 new high", v, 32'h0000_0002);

        // R6 staged low write leaves count alone
        load(40'h00_0000_1000);
        wr(2'd0, 32'hDEAD_0000);
        rd(2'd0, v); chk("R6 staged no effect", v, 32'h0000_1008);

        // R4 R8 rollover
        load(40'hFF_FFFF_FFF8);
        chk("R8 no pulse at load", {31'd0, wrap_pulse}, 32'd0);
        @(negedge clk);
        chk("R8 pulse", {31'd0, wrap_pulse}, 32'd1);
        @(negedge clk);
        chk("R8 one cycle", {31'd0, wrap_pulse}, 32'd0);
        rd(2'd0, v); chk("R4 wrapped low", v, 32'h0000_0008);
        rd(2'd1, v); chk("R4 wrapped high", v, 32'h0000_0000);

        // R3 negative quarter ns trim
        wr(2'd2, 32'hC000_0000);
        rd(2'd2, v); chk("R10 rate readback", v, 32'hC000_0000);
        load(40'h00_0000_1000);
        rd(2'd0, v); chk("R3 load", v, 32'h0000_1000);
        rd(2'd1, v);
        rd(2'd0, v); chk("R3 borrow step", v, 32'h0000_100F);

        // R2 positive quarter ns trim
        wr(2'd2, 32'h4000_0000);
        load(40'h00_0000_2000);
        rd(2'd0, v); chk("R2 load", v, 32'h0000_2000);
        rd(2'd1, v);
        rd(2'd0, v); chk("R2 no carry yet", v, 32'h0000_2010);
        rd(2'd1, v);
        rd(2'd0, v); chk("R2 carry step", v, 32'h0000_2021);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) wr(2'd2, $urandom);
            else if (op == 1) load({8'($urandom), 32'($urandom)});
            else if (op == 2) wr(2'd0, $urandom);
            else if (op == 3) begin rd(2'd2, v); chk("R10 random rate", v, m_exp); end
            else begin
                rd(2'd0, v); chk("R5 random low", v, m_exp);
                rd(2'd1, v); chk("R4 random high", v, m_exp);
            end
            chk("R8 random wrap", {31'd0, wrap_pulse}, {31'd0, m_wrap});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule